// File: doc/BRIEF.md
# I2C Bus Condition and Arbitration Unit

This unit sits between the two open-drain bus pins and a byte-level controller. It watches the synchronized clock and data lines for START, repeated START and STOP conditions and keeps a bus-busy flag. As a bus master it can produce each of these conditions itself. It moves one byte at a time, plus the acknowledge bit that follows the byte, through an 8-bit shift register and a separate acknowledge register. While it sends data bits it compares the line with what it released and backs off as soon as another master wins arbitration.

An external rate generator owns the clock line. It supplies two single-cycle strobes: `stb_low` in the middle of each clock-low phase and `stb_high` in the middle of each clock-high phase. The unit changes its data drive only on `stb_low` and samples the line only on `stb_high`. The exceptions are a START or STOP it generates on purpose and a release after lost arbitration. For correct sampling the system clock must run at least 16 times faster than the bus clock.

Byte work flows through two valid/ready streams. The unit accepts a byte operation (`op_*`) only while it owns the bus, is between bytes and has no result waiting. A finished byte is offered as a result (`res_*`) and held stable until `res_ready` is high. While the result is held, `op_ready` stays low, so back-pressure on the result also stops new bytes from being accepted. START and STOP commands are single-cycle pulses.

Top module: `i2c_line_unit`

## Requirements
- R1: After reset, `sda_oe`, `bus_busy`, `res_valid`, `op_ready` and all event pulses are 0.
- R2: A fall of the data line while the clock line is high, with the bus free, gives a one-cycle `ev_start` and sets `bus_busy`. A rise of the data line while the clock line is high gives a one-cycle `ev_stop` and clears `bus_busy`. Each event appears exactly 3 cycles after the pin change (two synchronizer stages plus one register).
- R3: A START condition while `bus_busy` is 1 gives `ev_rstart` instead of `ev_start`, with the same 3-cycle latency, and `bus_busy` stays 1.
- R4: `cmd_start` with the bus free makes the unit release the data line at a `stb_low` and pull it low at the next `stb_high`, which produces a START. After that `op_ready` rises. `cmd_start` while another master holds the bus is ignored: `sda_oe` stays 0.
- R5: A write operation (`op_write`=1) sends `op_data` most significant bit first. Each bit is set on a `stb_low`. The data line is released for the acknowledge bit. `res_ack` reports the level sampled there (0 = ACK, 1 = NACK), and `res_data` holds the byte seen on the bus. The data line does not change while the clock line is high during a byte.
- R6: A read operation (`op_write`=0) releases the data line for 8 bits and shifts in the sampled levels MSB first into `res_data`. In the acknowledge slot it drives the line low when `op_ack_send`=0 and releases it when `op_ack_send`=1. `res_ack` reports the level sent.
- R7: Once `res_valid` is 1 it stays 1, with `res_data` and `res_ack` stable, until a cycle with `res_ready`=1. `op_ready` is 0 while `res_valid` is 1.
- R8: `cmd_start` while the unit owns the bus between bytes produces a repeated START (`ev_rstart`, no `ev_start`), and `bus_busy` stays 1.
- R9: `cmd_stop` while the unit owns the bus drives the data line low on a `stb_low` and releases it on the next `stb_high`. This yields `ev_stop` and clears `bus_busy`. Afterwards `op_ready` and `sda_oe` are 0.
- R10: During a write data bit, if the unit has released the data line but samples it low on `stb_high`, `arb_lost` pulses in the next cycle. In that same cycle `sda_oe` is 0 and the unit gives up the bus: no result is produced and `op_ready` stays 0. A 0 bit driven by both masters is not a loss.
- R11: `ev_start`, `ev_rstart` and `ev_stop` are single-cycle pulses, and no two of them are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_pin | input | 1 | Clock line level from the pad |
| sda_pin | input | 1 | Data line level from the pad |
| stb_low | input | 1 | Rate generator strobe, middle of clock-low phase |
| stb_high | input | 1 | Rate generator strobe, middle of clock-high phase |
| cmd_start | input | 1 | Pulse: generate START or repeated START |
| cmd_stop | input | 1 | Pulse: generate STOP |
| op_valid | input | 1 | Byte operation offered |
| op_ready | output | 1 | Byte operation can be accepted |
| op_write | input | 1 | 1 = transmit byte, 0 = receive byte |
| op_data | input | 8 | Byte to transmit |
| op_ack_send | input | 1 | Acknowledge level to send after a received byte |
| res_valid | output | 1 | Byte result available |
| res_ready | input | 1 | Byte result taken |
| res_data | output | 8 | Byte seen on the bus |
| res_ack | output | 1 | Acknowledge level seen on the bus |
| sda_oe | output | 1 | 1 = pull data line low |
| bus_busy | output | 1 | Bus held between START and STOP |
| ev_start | output | 1 | START detected pulse |
| ev_rstart | output | 1 | Repeated START detected pulse |
| ev_stop | output | 1 | STOP detected pulse |
| arb_lost | output | 1 | Arbitration lost pulse |

## Verification
The condition detectors have a fixed latency: an event must be low at the falling clock edge two rising edges after the pin change and high at the one after the third rising edge. The bench checks both sides of that window. Byte results, arbitration loss and generated conditions follow the bus strobes. The bench therefore drives its own bus model in step with each `stb_low` and `stb_high`, checks `arb_lost` and `sda_oe` in the cycle after the losing `stb_high`, and samples the result only after the handshake edge. Back-pressure is tested by holding `res_ready` low for 40 cycles and confirming that the result stays stable and no new byte is accepted.

// File: rtl/i2c_line_pkg.sv
`timescale 1ns/1ps
package i2c_line_pkg;

  typedef enum logic [3:0] {
    MS_IDLE,
    MS_SREL,
    MS_SLOW,
    MS_HOLD,
    MS_BSET,
    MS_BSMP,
    MS_ASET,
    MS_ASMP,
    MS_PLOW,
    MS_PREL
  } mst_state_e;

  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_in[g]};
    end
    assign q_out[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/i2c_line_cond.sv
`timescale 1ns/1ps
module i2c_line_cond
  import i2c_line_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_s,
  input  logic    sda_s,
  output bus_ev_t ev,
  output logic    busy
);

  logic scl_q, sda_q;
  logic seen_fall, seen_rise;

  assign seen_fall = scl_s & scl_q & sda_q & ~sda_s;
  assign seen_rise = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      ev    <= '0;
      busy  <= 1'b0;
    end else begin
      scl_q     <= scl_s;
      sda_q     <= sda_s;
      ev.start  <= seen_fall & ~busy;
      ev.rstart <= seen_fall & busy;
      ev.stop   <= seen_rise;
      if (seen_fall)      busy <= 1'b1;
      else if (seen_rise) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_line_byte.sv
`timescale 1ns/1ps
module i2c_line_byte #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              ack_we,
  input  logic              ack_bit,
  input  logic              done,
  input  logic              res_ready,
  output logic              sh_msb,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_ack
);

  logic [DATA_W-1:0] shreg;
  logic              ackreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      ackreg    <= 1'b1;
      res_valid <= 1'b0;
    end else begin
      if (load)          shreg <= load_val;
      else if (shift_en) shreg <= {shreg[DATA_W-2:0], shift_bit};
      if (ack_we)        ackreg <= ack_bit;
      if (done)           res_valid <= 1'b1;
      else if (res_ready) res_valid <= 1'b0;
    end
  end

  assign sh_msb   = shreg[DATA_W-1];
  assign res_data = shreg;
  assign res_ack  = ackreg;

endmodule

// File: rtl/i2c_line_seq.sv
`timescale 1ns/1ps
module i2c_line_seq
  import i2c_line_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_low,
  input  logic stb_high,
  input  logic sda_s,
  input  logic bus_busy,
  input  logic cmd_start,
  input  logic cmd_stop,
  input  logic op_valid,
  input  logic op_write,
  input  logic op_ack_send,
  input  logic res_valid,
  input  logic sh_msb,
  output logic op_ready,
  output logic sda_oe,
  output logic arb_lost,
  output logic load,
  output logic shift_en,
  output logic shift_bit,
  output logic ack_we,
  output logic ack_bit,
  output logic done
);

  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

  mst_state_e    state;
  logic [CW-1:0] bit_cnt;
  logic          wr_q, ack_q;
  logic          lose;

  assign op_ready  = (state == MS_HOLD) && !res_valid;
  assign load      = op_ready && op_valid;
  assign lose      = (state == MS_BSMP) && stb_high && wr_q && !sda_oe && !sda_s;
  assign shift_en  = (state == MS_BSMP) && stb_high && !lose;
  assign shift_bit = sda_s;
  assign done      = (state == MS_ASMP) && stb_high;
  assign ack_we    = done;
  assign ack_bit   = sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= MS_IDLE;
      bit_cnt  <= '0;
      wr_q     <= 1'b0;
      ack_q    <= 1'b1;
      sda_oe   <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      arb_lost <= 1'b0;
      case (state)
        MS_IDLE: begin
          sda_oe <= 1'b0;
          if (cmd_start && !bus_busy) state <= MS_SREL;
        end
        MS_SREL: if (stb_low) begin
          sda_oe <= 1'b0;
          state  <= MS_SLOW;
        end
        MS_SLOW: if (stb_high) begin
          sda_oe <= 1'b1;
          state  <= MS_HOLD;
        end
        MS_HOLD: begin
          if (load) begin
            wr_q    <= op_write;
            ack_q   <= op_ack_send;
            bit_cnt <= '0;
            state   <= MS_BSET;
          end else if (cmd_start) begin
            state <= MS_SREL;
          end else if (cmd_stop) begin
            state <= MS_PLOW;
          end
        end
        MS_BSET: if (stb_low) begin
          sda_oe <= wr_q & ~sh_msb;
          state  <= MS_BSMP;
        end
        MS_BSMP: if (stb_high) begin
          if (lose) begin
            sda_oe   <= 1'b0;
            arb_lost <= 1'b1;
            state    <= MS_IDLE;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            state   <= (bit_cnt == LAST_BIT) ? MS_ASET : MS_BSET;
          end
        end
        MS_ASET: if (stb_low) begin
          sda_oe <= ~wr_q & ~ack_q;
          state  <= MS_ASMP;
        end
        MS_ASMP: if (stb_high) state <= MS_HOLD;
        MS_PLOW: if (stb_low) begin
          sda_oe <= 1'b1;
          state  <= MS_PREL;
        end
        MS_PREL: if (stb_high) begin
          sda_oe <= 1'b0;
          state  <= MS_IDLE;
        end
        default: begin
          sda_oe <= 1'b0;
          state  <= MS_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/i2c_line_unit.sv
`timescale 1ns/1ps
module i2c_line_unit
  import i2c_line_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_pin,
  input  logic              sda_pin,
  input  logic              stb_low,
  input  logic              stb_high,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_write,
  input  logic [DATA_W-1:0] op_data,
  input  logic              op_ack_send,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_ack,
  output logic              sda_oe,
  output logic              bus_busy,
  output logic              ev_start,
  output logic              ev_rstart,
  output logic              ev_stop,
  output logic              arb_lost
);

  logic [1:0] pins_s;
  logic       scl_s, sda_s;
  bus_ev_t    ev;
  logic       load, shift_en, shift_bit, ack_we, ack_bit, done, sh_msb;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_pin, sda_pin}),
    .q_out (pins_s)
  );

  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  i2c_line_cond u_cond (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_s (scl_s),
    .sda_s (sda_s),
    .ev    (ev),
    .busy  (bus_busy)
  );

  assign ev_start  = ev.start;
  assign ev_rstart = ev.rstart;
  assign ev_stop   = ev.stop;

  i2c_line_byte #(.DATA_W(DATA_W)) u_byte (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_val  (op_data),
    .shift_en  (shift_en),
    .shift_bit (shift_bit),
    .ack_we    (ack_we),
    .ack_bit   (ack_bit),
    .done      (done),
    .res_ready (res_ready),
    .sh_msb    (sh_msb),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_ack   (res_ack)
  );

  i2c_line_seq #(.DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb_low     (stb_low),
    .stb_high    (stb_high),
    .sda_s       (sda_s),
    .bus_busy    (bus_busy),
    .cmd_start   (cmd_start),
    .cmd_stop    (cmd_stop),
    .op_valid    (op_valid),
    .op_write    (op_write),
    .op_ack_send (op_ack_send),
    .res_valid   (res_valid),
    .sh_msb      (sh_msb),
    .op_ready    (op_ready),
    .sda_oe      (sda_oe),
    .arb_lost    (arb_lost),
    .load        (load),
    .shift_en    (shift_en),
    .shift_bit   (shift_bit),
    .ack_we      (ack_we),
    .ack_bit     (ack_bit),
    .done        (done)
  );

endmodule

// File: rtl/i2c_line_unit_chk.sv
`timescale 1ns/1ps
module i2c_line_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic              res_ack,
  input logic              sda_oe,
  input logic              bus_busy,
  input logic              ev_start,
  input logic              ev_rstart,
  input logic              ev_stop,
  input logic              arb_lost
);

  p_evt_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_rstart, ev_stop}));

  p_evt_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start || ev_rstart || ev_stop) |=> !(ev_start || ev_rstart || ev_stop));

  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> bus_busy);

  p_busy_off_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |-> !bus_busy);

  p_rstart_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rstart |-> (bus_busy && $past(bus_busy)));

  p_res_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_ack)));

  p_no_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !op_ready);

  p_arb_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (!sda_oe && !op_ready));

endmodule

bind i2c_line_unit i2c_line_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_ready  (op_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_ack   (res_ack),
  .sda_oe    (sda_oe),
  .bus_busy  (bus_busy),
  .ev_start  (ev_start),
  .ev_rstart (ev_rstart),
  .ev_stop   (ev_stop),
  .arb_lost  (arb_lost)
);

// File: tb/tb_i2c_line_unit.sv
`timescale 1ns/1ps
module tb_i2c_line_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       scl_man = 1'b1;
  logic       scl_run = 1'b0;
  logic       stb_low = 1'b0, stb_high = 1'b0;
  logic       pull = 1'b0;
  logic       cmd_start = 1'b0, cmd_stop = 1'b0;
  logic       op_valid = 1'b0, op_write = 1'b0, op_ack_send = 1'b1;
  logic [7:0] op_data = '0;
  logic       res_ready = 1'b0;
  logic       op_ready, res_valid, res_ack, sda_oe, bus_busy;
  logic       ev_start, ev_rstart, ev_stop, arb_lost;
  logic [7:0] res_data;
  logic       sda_bus;
  logic [8:0] mon = '0;
  logic       mon_en = 1'b0;
  logic       scl_q = 1'b1, sda_q = 1'b1;
  int         viol = 0;
  int         ph = 0;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign sda_bus = !(sda_oe || pull);

  i2c_line_unit dut (
    .clk(clk), .rst_n(rst_n), .scl_pin(scl), .sda_pin(sda_bus),
    .stb_low(stb_low), .stb_high(stb_high), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .op_valid(op_valid), .op_ready(op_ready), .op_write(op_write), .op_data(op_data),
    .op_ack_send(op_ack_send), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_ack(res_ack), .sda_oe(sda_oe), .bus_busy(bus_busy),
    .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop), .arb_lost(arb_lost)
  );

  // Bus clock model: 32 system cycles per bus period, strobes mid-phase
  always @(negedge clk) begin
    if (!scl_run) begin
      ph <= 0; scl <= scl_man; stb_low <= 1'b0; stb_high <= 1'b0;
    end else begin
      ph       <= (ph == 31) ? 0 : ph + 1;
      scl      <= (ph >= 16);
      stb_low  <= (ph == 8);
      stb_high <= (ph == 24);
    end
  end

  always @(posedge scl) if (mon_en) mon <= {mon[7:0], sda_bus};

  always @(negedge clk) begin
    if (mon_en && scl && scl_q && (sda_bus != sda_q)) viol <= viol + 1;
    scl_q <= scl;
    sda_q <= sda_bus;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] evv();
    return {ev_start, ev_rstart, ev_stop};
  endfunction

  // Drive the data line and check the event window (low after 2 edges, high after 3)
  task automatic ext_edge(input logic new_pull, input logic [2:0] exp_ev, input string req);
    @(negedge clk) pull = new_pull;
    repeat (2) @(posedge clk);
    @(negedge clk) chk(evv() == 3'b000, req, "event too early", int'(evv()), 0);
    @(posedge clk);
    @(negedge clk) chk(evv() == exp_ev, req, "event at latency 3", int'(evv()), int'(exp_ev));
    @(posedge clk);
    @(negedge clk) chk(evv() == 3'b000, req, "event one cycle wide", int'(evv()), 0);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sda_oe && !bus_busy && !res_valid && !op_ready, "R1", "reset outputs",
        int'({sda_oe, bus_busy, res_valid, op_ready}), 0);
    chk(evv() == 3'b000 && !arb_lost, "R1", "reset events", int'({evv(), arb_lost}), 0);
  endtask

  task automatic t_ext_conditions();
    int oe_seen = 0;
    ext_edge(1'b1, 3'b100, "R2");
    chk(bus_busy, "R2", "busy after START", int'(bus_busy), 1);
    // R4: start command while another master owns the bus
    @(negedge clk) cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
    scl_run = 1'b1;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      if (sda_oe || op_ready) oe_seen++;
    end
    chk(oe_seen == 0, "R4", "ignored start while busy", oe_seen, 0);
    scl_man = 1'b1; scl_run = 1'b0;
    repeat (4) @(negedge clk);
    // repeated START from outside
    scl_man = 1'b0; repeat (4) @(negedge clk);
    pull = 1'b0;    repeat (4) @(negedge clk);
    scl_man = 1'b1; repeat (4) @(negedge clk);
    ext_edge(1'b1, 3'b010, "R3");
    chk(bus_busy, "R3", "busy kept on repeated START", int'(bus_busy), 1);
    // STOP from outside
    scl_man = 1'b0; repeat (4) @(negedge clk);
    scl_man = 1'b1; repeat (4) @(negedge clk);
    ext_edge(1'b0, 3'b001, "R2");
    chk(!bus_busy, "R2", "busy cleared by STOP", int'(bus_busy), 0);
  endtask

  task automatic t_master_start();
    scl_run = 1'b1;
    @(negedge clk) cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
    @(posedge clk iff ev_start);
    @(negedge clk);
    chk(bus_busy && sda_oe, "R4", "START generated, line held low",
        int'({bus_busy, sda_oe}), 3);
    @(posedge clk iff op_ready);
    @(negedge clk) chk(op_ready, "R4", "op_ready after START", int'(op_ready), 1);
  endtask

  task automatic do_byte(input bit wr, input logic [7:0] d, input bit acks,
                         input logic [8:0] pat, input logic [7:0] exp_d, input bit exp_a,
                         input logic [8:0] exp_mon, input bit bp, input string req);
    logic [7:0] held;
    @(negedge clk);
    op_valid = 1'b1; op_write = wr; op_data = d; op_ack_send = acks;
    @(posedge clk iff op_ready);
    @(negedge clk) op_valid = 1'b0;
    viol = 0;
    for (int i = 0; i < 9; i++) begin
      @(posedge clk iff stb_low);
      @(negedge clk) pull = pat[8-i];
      mon_en = 1'b1;
      @(posedge clk iff stb_high);
    end
    @(posedge clk iff res_valid);
    @(negedge clk) mon_en = 1'b0;
    chk(res_data == exp_d, req, "result byte", int'(res_data), int'(exp_d));
    chk(res_ack == exp_a, req, "result ack", int'(res_ack), int'(exp_a));
    chk(mon == exp_mon, req, "bus bits MSB first", int'(mon), int'(exp_mon));
    chk(viol == 0, "R5", "data change while clock high", viol, 0);
    if (bp) begin
      held = res_data;
      repeat (40) @(negedge clk);
      chk(res_valid && res_data == held && !op_ready, "R7", "result held under back-pressure",
          int'({res_valid, op_ready, res_data}), int'({2'b10, held}));
    end
    @(negedge clk) res_ready = 1'b1;
    @(negedge clk) res_ready = 1'b0;
    chk(!res_valid, "R7", "result taken", int'(res_valid), 0);
    @(posedge clk iff stb_low);
    @(negedge clk) pull = 1'b0;
  endtask

  task automatic t_rstart();
    @(negedge clk) cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
    @(posedge clk iff (ev_rstart || ev_start));
    @(negedge clk);
    chk(!ev_start && bus_busy, "R8", "repeated START generated", int'({ev_start, bus_busy}), 1);
    @(posedge clk iff op_ready);
  endtask

  task automatic t_stop();
    @(negedge clk) cmd_stop = 1'b1;
    @(negedge clk) cmd_stop = 1'b0;
    @(posedge clk iff ev_stop);
    @(negedge clk);
    chk(!bus_busy && !op_ready && !sda_oe, "R9", "STOP frees bus",
        int'({bus_busy, op_ready, sda_oe}), 0);
  endtask

  task automatic t_arb();
    int stray = 0;
    t_master_start();
    @(negedge clk);
    op_valid = 1'b1; op_write = 1'b1; op_data = 8'h5F; op_ack_send = 1'b1;
    @(posedge clk iff op_ready);
    @(negedge clk) op_valid = 1'b0;
    // other master sends 0 then 0; the unit sends 0 then 1
    for (int i = 0; i < 2; i++) begin
      @(posedge clk iff stb_low);
      @(negedge clk) pull = 1'b1;
      @(posedge clk iff stb_high);
      @(negedge clk);
      if (i == 0) chk(!arb_lost && sda_oe, "R10", "no loss on shared 0",
                      int'({arb_lost, sda_oe}), 1);
      else        chk(arb_lost && !sda_oe, "R10", "loss flagged and line released",
                      int'({arb_lost, sda_oe}), 2);
    end
    @(negedge clk) chk(!arb_lost, "R10", "loss pulse one cycle", int'(arb_lost), 0);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (res_valid || op_ready || sda_oe) stray++;
    end
    chk(stray == 0, "R10", "no result or drive after loss", stray, 0);
    // other master finishes with a STOP
    @(posedge clk iff stb_low);
    @(negedge clk) pull = 1'b1;
    @(posedge clk iff stb_high);
    @(negedge clk) pull = 1'b0;
    @(posedge clk iff ev_stop);
    @(negedge clk) chk(!bus_busy, "R2", "busy cleared after foreign STOP", int'(bus_busy), 0);
  endtask

  initial begin
    t_reset();
    t_ext_conditions();
    t_master_start();
    do_byte(1'b1, 8'hA5, 1'b1, 9'b0_0000_0001, 8'hA5, 1'b0, {8'hA5, 1'b0}, 1'b1, "R5");
    do_byte(1'b1, 8'h3C, 1'b1, 9'b0_0000_0000, 8'h3C, 1'b1, {8'h3C, 1'b1}, 1'b0, "R5");
    do_byte(1'b0, 8'h00, 1'b1, {~8'h5A, 1'b0}, 8'h5A, 1'b1, {8'h5A, 1'b1}, 1'b0, "R6");
    t_rstart();
    do_byte(1'b0, 8'h00, 1'b0, {~8'h96, 1'b0}, 8'h96, 1'b0, {8'h96, 1'b0}, 1'b1, "R6");
    t_stop();
    t_arb();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule